// File: doc/BRIEF.md
# Load/Store Alignment Unit

This block is the memory-access stage of a 32-bit core that uses a fixed immediate-format instruction word. It takes one load or store instruction at a time together with the value of its base register. It adds the sign-extended 16-bit offset to that value to form a byte address. It then issues a single word request to a big-endian, byte-addressed memory port with per-byte write strobes. On a load it picks the addressed byte or halfword out of the returned word and widens it with sign or zero fill, then presents the result for register writeback. Writeback to register zero is dropped.

Stores always take the low byte or low halfword of the source register. That value is repeated across the data bus and the byte enables mark the addressed lane. Double-precision transfers move an even/odd register pair as two word beats in successive request cycles. The even register goes to the effective address and the odd register to the following word. The memory answers each request with a ready strobe in the same cycle. A beat with ready low is held unchanged until ready rises.

Top module: `lsu_align`

## Requirements
- R1: The instruction word carries the opcode in bits [31:26], the base register index in [25:21], the data register index in [20:16] and the offset in [15:0]. `base_idx` and `src_idx` show bits [25:21] and [20:16] combinationally. The effective address is `base_val` plus the sign-extended offset. `mem_addr` is that address with bits [1:0] cleared.
- R2: Accepted opcodes are 0x01 signed byte load, 0x02 unsigned byte load, 0x03 signed halfword load, 0x04 unsigned halfword load, 0x05 word load, 0x06 single-float load, 0x07 pair load, 0x09 byte store, 0x0A halfword store, 0x0B word store, 0x0C single-float store and 0x0D pair store. Any other opcode raises no request and leaves `op_ready` high.
- R3: For a byte load, address offset k selects `mem_rdata` bits [31-8k:24-8k]. The byte is sign-extended for opcode 0x01 and zero-extended for 0x02.
- R4: For a halfword load, address bit 1 low selects bits [31:16] and high selects bits [15:0]. The halfword is sign-extended for opcode 0x03 and zero-extended for 0x04.
- R5: Word and single-float loads return all 32 bits unchanged, and address bits [1:0] have no effect on them.
- R6: `mem_be[i]` marks `mem_wdata[8i+7:8i]`. A byte access enables only bit 3-k for offset k. A halfword access enables [3:2] when address bit 1 is low and [1:0] when it is high. The same lane rule holds for loads. A byte store repeats the low byte of `src_lo` in all four lanes, and a halfword store repeats the low halfword twice.
- R7: Word and single-float stores drive `src_lo` as written and set all four byte enables, whatever address bits [1:0] hold.
- R8: A load whose destination is register 0 never raises `wb_en`. Stores never raise `wb_en`.
- R9: A pair access ignores bit 0 of the data register index. Its first beat moves the even register at the effective word address, using `src_lo` for stores. Its second beat, in the next request cycle, moves the odd register at that address plus 4, using `src_hi` for stores.
- R10: `op_ready` is low while a request is outstanding, and `op_valid` is ignored while it is low. A request stays raised with stable address, enables and direction until `mem_ready` is high. `wb_en`, `wb_idx` and `wb_data` appear in the cycle after the beat that completed.
- R11: Reset is synchronous and active low. After a clock edge with reset asserted, `mem_req` and `wb_en` are low and `op_ready` is high, even if a request was outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Instruction presented |
| op_instr | input | 32 | Instruction word |
| op_ready | output | 1 | Block can take an instruction |
| base_idx | output | 5 | Base register index for the register file |
| src_idx | output | 5 | Data register index for the register file |
| base_val | input | 32 | Value of the base register |
| src_lo | input | 32 | Store data, or even register of a pair |
| src_hi | input | 32 | Odd register of a pair store |
| mem_req | output | 1 | Memory request raised |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_be | output | 4 | Byte enables, bit 3 = lowest address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Memory completes the current beat |
| wb_en | output | 1 | Register write strobe |
| wb_idx | output | 5 | Register written |
| wb_data | output | 32 | Value written |

## Verification
The assertions assume a few things about the inputs. `mem_ready` is only meaningful while `mem_req` is high. The instruction and register values hold steady in the cycle they are accepted. No instruction arrives until `op_ready` returns. The bench raises `op_valid` for a single cycle in which `op_ready` is high, except where it deliberately waves an instruction during a stall to show it is ignored. It drives `mem_rdata` before the beat that samples it and lowers `mem_ready` only while a request is raised.

// File: rtl/lsu_pkg.sv
// Shared types and opcode values for the load/store alignment unit.
// Assumes a fixed 32-bit instruction word: opcode, base index, data index, offset.
package lsu_pkg;
    localparam int OPW  = 6;
    localparam int REGW = 5;
    localparam int IMMW = 16;
    localparam int XLEN = 32;

    typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2} size_e;

    typedef struct packed {
        logic  is_store;
        logic  is_signed;
        logic  is_pair;
        size_e size;
    } acc_t;

    typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_FIRST = 2'd1, ST_SECOND = 2'd2} st_e;

    localparam logic [OPW-1:0] OPC_LDBS = 6'h01;
    localparam logic [OPW-1:0] OPC_LDBU = 6'h02;
    localparam logic [OPW-1:0] OPC_LDHS = 6'h03;
    localparam logic [OPW-1:0] OPC_LDHU = 6'h04;
    localparam logic [OPW-1:0] OPC_LDW  = 6'h05;
    localparam logic [OPW-1:0] OPC_LDSP = 6'h06;
    localparam logic [OPW-1:0] OPC_LDDP = 6'h07;
    localparam logic [OPW-1:0] OPC_STB  = 6'h09;
    localparam logic [OPW-1:0] OPC_STH  = 6'h0A;
    localparam logic [OPW-1:0] OPC_STW  = 6'h0B;
    localparam logic [OPW-1:0] OPC_STSP = 6'h0C;
    localparam logic [OPW-1:0] OPC_STDP = 6'h0D;
endpackage

// File: rtl/lsu_decode.sv
// Instruction field split, opcode decode and effective-address adder.
// Purely combinational; assumes the instruction and base value are stable
// in the cycle the caller samples the outputs.
module lsu_decode
    import lsu_pkg::*;
#(
    parameter int XW = XLEN,
    parameter int OW = OPW,
    parameter int RW = REGW,
    parameter int IW = IMMW
) (
    input  logic [OW+2*RW+IW-1:0] instr,
    input  logic [XW-1:0]         base,
    output logic                  hit,
    output acc_t                  acc,
    output logic [RW-1:0]         rs_idx,
    output logic [RW-1:0]         rd_idx,
    output logic [XW-1:0]         ea
);
    localparam int ILEN = OW + 2 * RW + IW;

    logic [OW-1:0] opc;
    logic [IW-1:0] imm;

    assign opc    = instr[ILEN-1 -: OW];
    assign rs_idx = instr[IW+RW +: RW];
    assign rd_idx = instr[IW +: RW];
    assign imm    = instr[IW-1:0];

    // Effective address: base plus sign-extended offset.
    assign ea = base + {{(XW-IW){imm[IW-1]}}, imm};

    // Opcode to access-kind decode; unknown opcodes clear hit.
    always_comb begin
        hit = 1'b1;
        acc = '{is_store: 1'b0, is_signed: 1'b0, is_pair: 1'b0, size: SZ_WORD};
        case (opc)
            OPC_LDBS: begin acc.size = SZ_BYTE; acc.is_signed = 1'b1; end
            OPC_LDBU: acc.size = SZ_BYTE;
            OPC_LDHS: begin acc.size = SZ_HALF; acc.is_signed = 1'b1; end
            OPC_LDHU: acc.size = SZ_HALF;
            OPC_LDW, OPC_LDSP: acc.size = SZ_WORD;
            OPC_LDDP: acc.is_pair = 1'b1;
            OPC_STB:  begin acc.size = SZ_BYTE; acc.is_store = 1'b1; end
            OPC_STH:  begin acc.size = SZ_HALF; acc.is_store = 1'b1; end
            OPC_STW, OPC_STSP: acc.is_store = 1'b1;
            OPC_STDP: begin acc.is_store = 1'b1; acc.is_pair = 1'b1; end
            default:  hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/lsu_lane.sv
// Big-endian lane steering: byte enables, store replication and load
// extraction with sign or zero fill. Lane 0 (lowest address) sits in the
// most significant byte. Assumes alignment is not checked.
module lsu_lane
    import lsu_pkg::*;
#(
    parameter int XW = XLEN
) (
    input  size_e                    size,
    input  logic                     is_signed,
    input  logic [$clog2(XW/8)-1:0]  off,
    input  logic [XW-1:0]            st_src,
    input  logic [XW-1:0]            ld_word,
    output logic [XW/8-1:0]          be,
    output logic [XW-1:0]            st_data,
    output logic [XW-1:0]            ld_data
);
    localparam int LANES  = XW / 8;
    localparam int HALVES = LANES / 2;
    localparam int OFFW   = $clog2(LANES);

    logic [OFFW-1:0] byte_sel;
    logic [OFFW-2:0] half_sel;
    logic [7:0]      byte_v;
    logic [15:0]     half_v;

    // Map the address offset to the bus lane, reversed for big-endian order.
    assign byte_sel = OFFW'(LANES - 1) - off;
    assign half_sel = (OFFW-1)'(HALVES - 1) - off[OFFW-1:1];
    assign byte_v   = ld_word[{byte_sel, 3'b000} +: 8];
    assign half_v   = ld_word[{half_sel, 4'b0000} +: 16];

    // Per-size enables, replicated store data and extended load data.
    always_comb begin
        be = '0;
        case (size)
            SZ_BYTE: begin
                be[byte_sel] = 1'b1;
                st_data = {LANES{st_src[7:0]}};
                ld_data = {{(XW-8){is_signed & byte_v[7]}}, byte_v};
            end
            SZ_HALF: begin
                be[{half_sel, 1'b0} +: 2] = 2'b11;
                st_data = {HALVES{st_src[15:0]}};
                ld_data = {{(XW-16){is_signed & half_v[15]}}, half_v};
            end
            default: begin
                be      = '1;
                st_data = st_src;
                ld_data = ld_word;
            end
        endcase
    end
endmodule

// File: rtl/lsu_seq.sv
// Beat sequencer: idle, first beat, optional second beat for pair accesses.
// Assumes ready is only sampled while busy.
module lsu_seq
    import lsu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic pair,
    input  logic ready,
    output logic busy,
    output logic beat,
    output logic fire
);
    st_e state, state_nx;

    assign busy = (state != ST_IDLE);
    assign beat = (state == ST_SECOND);
    assign fire = busy & ready;

    // Next-state choice for the beat sequence.
    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE:   if (start) state_nx = ST_FIRST;
            ST_FIRST:  if (ready) state_nx = pair ? ST_SECOND : ST_IDLE;
            ST_SECOND: if (ready) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // R10
    hold_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ready) |=> (busy && $stable(beat)));
endmodule

// File: rtl/lsu_align.sv
// Load/store alignment unit top: latches an accepted instruction, issues
// one or two word beats to a single-cycle request/ready memory port and
// registers the extended load result for writeback. Assumes big-endian
// byte order and ignores misalignment.
module lsu_align
    import lsu_pkg::*;
#(
    parameter int XW = XLEN,
    parameter int OW = OPW,
    parameter int RW = REGW,
    parameter int IW = IMMW
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  op_valid,
    input  logic [OW+2*RW+IW-1:0] op_instr,
    output logic                  op_ready,
    output logic [RW-1:0]         base_idx,
    output logic [RW-1:0]         src_idx,
    input  logic [XW-1:0]         base_val,
    input  logic [XW-1:0]         src_lo,
    input  logic [XW-1:0]         src_hi,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [XW-1:0]         mem_addr,
    output logic [XW/8-1:0]       mem_be,
    output logic [XW-1:0]         mem_wdata,
    input  logic [XW-1:0]         mem_rdata,
    input  logic                  mem_ready,
    output logic                  wb_en,
    output logic [RW-1:0]         wb_idx,
    output logic [XW-1:0]         wb_data
);
    localparam int LANES = XW / 8;
    localparam int OFFW  = $clog2(LANES);

    logic          hit, accept, busy, beat, fire;
    acc_t          acc, acc_q;
    logic [RW-1:0] rd_dec, rd_q, dest;
    logic [XW-1:0] ea, ea_q, lo_q, hi_q, ld_data;

    lsu_decode #(.XW(XW), .OW(OW), .RW(RW), .IW(IW)) dec_i (
        .instr(op_instr), .base(base_val), .hit(hit), .acc(acc),
        .rs_idx(base_idx), .rd_idx(rd_dec), .ea(ea)
    );

    assign src_idx  = rd_dec;
    assign op_ready = !busy;
    assign accept   = op_valid & op_ready & hit;

    lsu_seq seq_i (
        .clk(clk), .rst_n(rst_n), .start(accept), .pair(acc_q.is_pair),
        .ready(mem_ready), .busy(busy), .beat(beat), .fire(fire)
    );

    // Capture the accepted request's address, kind, register and data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea_q  <= '0;
            acc_q <= '{is_store: 1'b0, is_signed: 1'b0, is_pair: 1'b0, size: SZ_WORD};
            rd_q  <= '0;
            lo_q  <= '0;
            hi_q  <= '0;
        end else if (accept) begin
            ea_q  <= ea;
            acc_q <= acc;
            rd_q  <= rd_dec;
            lo_q  <= src_lo;
            hi_q  <= src_hi;
        end
    end

    lsu_lane #(.XW(XW)) lane_i (
        .size(acc_q.size), .is_signed(acc_q.is_signed), .off(ea_q[OFFW-1:0]),
        .st_src(beat ? hi_q : lo_q), .ld_word(mem_rdata),
        .be(mem_be), .st_data(mem_wdata), .ld_data(ld_data)
    );

    // Memory request: word-aligned address, second beat one word higher.
    assign mem_req  = busy;
    assign mem_we   = busy & acc_q.is_store;
    assign mem_addr = {ea_q[XW-1:OFFW], {OFFW{1'b0}}} + (beat ? XW'(LANES) : '0);

    // Pair beats go to the even then odd register.
    assign dest = acc_q.is_pair ? {rd_q[RW-1:1], beat} : rd_q;

    // Writeback register, loaded on each completed load beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_en   <= 1'b0;
            wb_idx  <= '0;
            wb_data <= '0;
        end else begin
            wb_en <= fire & !acc_q.is_store & (dest != '0);
            if (fire & !acc_q.is_store) begin
                wb_idx  <= dest;
                wb_data <= ld_data;
            end
        end
    end

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_be) && $stable(mem_we)));

    // R8
    no_zero_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (wb_idx != '0));

    // R10
    wb_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> $past(mem_req && mem_ready && !mem_we));

    // R9
    pair_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && $past(mem_req && mem_ready)) |-> (mem_addr == $past(mem_addr) + XW'(LANES)));

    // R6
    be_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 || $countones(mem_be) == LANES));
endmodule

// File: tb/lsu_align_tb.sv
// Self-checking bench: a vector table for single-beat accesses, then
// directed tests for pairs, stalls, ignored opcodes and reset.
module lsu_align_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [31:0] op_instr = '0;
    logic        op_ready;
    logic [4:0]  base_idx, src_idx;
    logic [31:0] base_val = '0, src_lo = '0, src_hi = '0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [3:0]  mem_be;
    logic [31:0] mem_rdata = '0;
    logic        mem_ready = 1'b1;
    logic        wb_en;
    logic [4:0]  wb_idx;
    logic [31:0] wb_data;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    lsu_align dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_instr(op_instr),
        .op_ready(op_ready), .base_idx(base_idx), .src_idx(src_idx),
        .base_val(base_val), .src_lo(src_lo), .src_hi(src_hi),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data)
    );

    typedef struct packed {
        logic [5:0]  op;
        logic [4:0]  rd;
        logic [15:0] imm;
        logic [31:0] base;
        logic [31:0] src;
        logic [31:0] rdata;
        logic [31:0] addr;
        logic [3:0]  be;
        logic        we;
        logic [31:0] wdata;
        logic        wb;
        logic [4:0]  idx;
        logic [31:0] wbd;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        // R3 signed byte, offset 1
        '{6'h01, 5'd5,  16'h0001, 32'h1000, 32'h0, 32'h11853344, 32'h1000, 4'b0100, 1'b0, 32'h0, 1'b1, 5'd5,  32'hFFFFFF85, 4'd3},
        // R3 unsigned byte, offset 1
        '{6'h02, 5'd6,  16'h0001, 32'h1000, 32'h0, 32'h11853344, 32'h1000, 4'b0100, 1'b0, 32'h0, 1'b1, 5'd6,  32'h00000085, 4'd3},
        // R3 signed byte, offset 3, positive
        '{6'h01, 5'd7,  16'h0003, 32'h2000, 32'h0, 32'h0000007F, 32'h2000, 4'b0001, 1'b0, 32'h0, 1'b1, 5'd7,  32'h0000007F, 4'd3},
        // R4 signed halfword, low half, negative offset (R1)
        '{6'h03, 5'd8,  16'hFFFE, 32'h3000, 32'h0, 32'h12348001, 32'h2FFC, 4'b0011, 1'b0, 32'h0, 1'b1, 5'd8,  32'hFFFF8001, 4'd4},
        // R4 unsigned halfword, high half
        '{6'h04, 5'd9,  16'h0000, 32'h3000, 32'h0, 32'hABCD0000, 32'h3000, 4'b1100, 1'b0, 32'h0, 1'b1, 5'd9,  32'h0000ABCD, 4'd4},
        // R5 word load, low bits ignored
        '{6'h05, 5'd10, 16'h0007, 32'h4000, 32'h0, 32'hDEADBEEF, 32'h4004, 4'b1111, 1'b0, 32'h0, 1'b1, 5'd10, 32'hDEADBEEF, 4'd5},
        // R5 single-float load
        '{6'h06, 5'd11, 16'h0000, 32'h5000, 32'h0, 32'h3F800000, 32'h5000, 4'b1111, 1'b0, 32'h0, 1'b1, 5'd11, 32'h3F800000, 4'd5},
        // R8 load into register 0
        '{6'h05, 5'd0,  16'h0000, 32'h6000, 32'h0, 32'hCAFEF00D, 32'h6000, 4'b1111, 1'b0, 32'h0, 1'b0, 5'd0,  32'h0,        4'd8},
        // R6 byte store, offset 2
        '{6'h09, 5'd12, 16'h0002, 32'h7000, 32'h11223344, 32'h0, 32'h7000, 4'b0010, 1'b1, 32'h44444444, 1'b0, 5'd0, 32'h0, 4'd6},
        // R6 halfword store, high half
        '{6'h0A, 5'd13, 16'h0000, 32'h7000, 32'hAAAA5678, 32'h0, 32'h7000, 4'b1100, 1'b1, 32'h56785678, 1'b0, 5'd0, 32'h0, 4'd6},
        // R6 halfword store, low half
        '{6'h0A, 5'd13, 16'h0002, 32'h7000, 32'hAAAA5678, 32'h0, 32'h7000, 4'b0011, 1'b1, 32'h56785678, 1'b0, 5'd0, 32'h0, 4'd6},
        // R7 word store, misaligned address
        '{6'h0B, 5'd14, 16'hFFF3, 32'h7010, 32'h01234567, 32'h0, 32'h7000, 4'b1111, 1'b1, 32'h01234567, 1'b0, 5'd0, 32'h0, 4'd7},
        // R7 single-float store
        '{6'h0C, 5'd15, 16'h0004, 32'h7000, 32'h40490FDB, 32'h0, 32'h7004, 4'b1111, 1'b1, 32'h40490FDB, 1'b0, 5'd0, 32'h0, 4'd7},
        // R3 signed byte, offset 0, top lane
        '{6'h01, 5'd1,  16'h0000, 32'h0100, 32'h0, 32'h80FFFFFF, 32'h0100, 4'b1000, 1'b0, 32'h0, 1'b1, 5'd1,  32'hFFFFFF80, 4'd3},
        // R1 most negative offset
        '{6'h05, 5'd2,  16'h8000, 32'h00010000, 32'h0, 32'h5A5A5A5A, 32'h00008000, 4'b1111, 1'b0, 32'h0, 1'b1, 5'd2, 32'h5A5A5A5A, 4'd1}
    };

    // Compare one value and log a failure line.
    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] rd, input logic [15:0] imm);
        return {op, 5'd9, rd, imm};
    endfunction

    // Present one instruction for a single cycle.
    task automatic issue(input logic [31:0] ins, input logic [31:0] b, input logic [31:0] lo, input logic [31:0] hi);
        @(negedge clk);
        op_valid = 1'b1; op_instr = ins; base_val = b; src_lo = lo; src_hi = hi;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11", "mem_req in reset", {31'b0, mem_req}, 32'd0);
        chk("R11", "wb_en in reset", {31'b0, wb_en}, 32'd0);
        chk("R11", "op_ready in reset", {31'b0, op_ready}, 32'd1);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            automatic vec_t v = VECS[i];
            automatic string rq = $sformatf("R%0d", v.req);
            @(negedge clk);
            op_valid = 1'b1; op_instr = mk(v.op, v.rd, v.imm);
            base_val = v.base; src_lo = v.src; src_hi = 32'h0; mem_rdata = v.rdata;
            #1;
            chk("R1", "base_idx", {27'b0, base_idx}, 32'd9);
            chk("R1", "src_idx", {27'b0, src_idx}, {27'b0, v.rd});
            @(negedge clk);
            op_valid = 1'b0;
            chk("R10", "op_ready busy", {31'b0, op_ready}, 32'd0);
            chk("R2", "mem_req", {31'b0, mem_req}, 32'd1);
            chk(rq, "mem_we", {31'b0, mem_we}, {31'b0, v.we});
            chk(rq, "mem_addr", mem_addr, v.addr);
            chk(rq, "mem_be", {28'b0, mem_be}, {28'b0, v.be});
            if (v.we) chk(rq, "mem_wdata", mem_wdata, v.wdata);
            @(negedge clk);
            chk(rq, "wb_en", {31'b0, wb_en}, {31'b0, v.wb});
            if (v.wb) begin
                chk(rq, "wb_idx", {27'b0, wb_idx}, {27'b0, v.idx});
                chk(rq, "wb_data", wb_data, v.wbd);
            end
            chk("R10", "mem_req drop", {31'b0, mem_req}, 32'd0);
        end

        // R2 unknown opcode raises nothing
        issue(mk(6'h3F, 5'd4, 16'h0), 32'h100, 32'h0, 32'h0);
        chk("R2", "unknown op mem_req", {31'b0, mem_req}, 32'd0);
        chk("R2", "unknown op op_ready", {31'b0, op_ready}, 32'd1);
        @(negedge clk);
        chk("R2", "unknown op wb_en", {31'b0, wb_en}, 32'd0);

        // R9 pair load into rd 3 -> registers 2 then 3
        mem_rdata = 32'h11111111;
        issue(mk(6'h07, 5'd3, 16'h0008), 32'h8000, 32'h0, 32'h0);
        chk("R9", "pair ld beat0 addr", mem_addr, 32'h8008);
        chk("R9", "pair ld beat0 be", {28'b0, mem_be}, 32'hF);
        @(negedge clk);
        chk("R9", "pair ld beat1 addr", mem_addr, 32'h800C);
        chk("R9", "pair ld even wb_en", {31'b0, wb_en}, 32'd1);
        chk("R9", "pair ld even idx", {27'b0, wb_idx}, 32'd2);
        chk("R9", "pair ld even data", wb_data, 32'h11111111);
        mem_rdata = 32'h22222222;
        @(negedge clk);
        chk("R9", "pair ld odd idx", {27'b0, wb_idx}, 32'd3);
        chk("R9", "pair ld odd data", wb_data, 32'h22222222);
        chk("R9", "pair ld done", {31'b0, mem_req}, 32'd0);

        // R9 pair store
        issue(mk(6'h0D, 5'd4, 16'hFFFC), 32'h9000, 32'hAAAA0001, 32'hBBBB0002);
        chk("R9", "pair st beat0 addr", mem_addr, 32'h8FFC);
        chk("R9", "pair st beat0 data", mem_wdata, 32'hAAAA0001);
        @(negedge clk);
        chk("R9", "pair st beat1 addr", mem_addr, 32'h9000);
        chk("R9", "pair st beat1 data", mem_wdata, 32'hBBBB0002);
        chk("R8", "pair st no wb", {31'b0, wb_en}, 32'd0);

        // R8 pair load into register 0: only register 1 written
        @(negedge clk);
        mem_rdata = 32'h0BAD0BAD;
        issue(mk(6'h07, 5'd0, 16'h0000), 32'hA000, 32'h0, 32'h0);
        @(negedge clk);
        chk("R8", "pair r0 even suppressed", {31'b0, wb_en}, 32'd0);
        mem_rdata = 32'h600DF00D;
        @(negedge clk);
        chk("R8", "pair r0 odd wb_en", {31'b0, wb_en}, 32'd1);
        chk("R8", "pair r0 odd idx", {27'b0, wb_idx}, 32'd1);
        chk("R8", "pair r0 odd data", wb_data, 32'h600DF00D);

        // R10 stall: request held, new instruction ignored
        mem_ready = 1'b0;
        mem_rdata = 32'h13579BDF;
        issue(mk(6'h05, 5'd20, 16'h0010), 32'hB000, 32'h0, 32'h0);
        chk("R10", "stall req", {31'b0, mem_req}, 32'd1);
        op_valid = 1'b1; op_instr = mk(6'h0B, 5'd21, 16'h0); base_val = 32'hC000;
        @(negedge clk);
        op_valid = 1'b0;
        chk("R10", "stall req held", {31'b0, mem_req}, 32'd1);
        chk("R10", "stall addr held", mem_addr, 32'hB010);
        chk("R10", "stall we held", {31'b0, mem_we}, 32'd0);
        chk("R10", "stall no wb", {31'b0, wb_en}, 32'd0);
        mem_ready = 1'b1;
        @(negedge clk);
        chk("R10", "stall wb_en", {31'b0, wb_en}, 32'd1);
        chk("R10", "stall wb_data", wb_data, 32'h13579BDF);
        chk("R10", "busy op ignored", {31'b0, mem_req}, 32'd0);

        // R11 reset while a request is outstanding
        mem_ready = 1'b0;
        issue(mk(6'h05, 5'd22, 16'h0000), 32'hD000, 32'h0, 32'h0);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R11", "reset drops req", {31'b0, mem_req}, 32'd0);
        chk("R11", "reset op_ready", {31'b0, op_ready}, 32'd1);
        chk("R11", "reset wb_en", {31'b0, wb_en}, 32'd0);
        rst_n = 1'b1;
        mem_ready = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule